// File: doc/BRIEF.md
# Mixed Read-Only and Read/Write Byte Memory

This block is a 4096-word by 8-bit memory with a single address space. The space is built from four uniform 1024-word banks. The lowest bank is read-only: it holds constants that are fixed when the design is built, and it has no write path. The three banks above it are static read/write storage. The top two address bits pick a bank, and the low ten bits pick a word inside that bank. The decode is kept as small as possible.

A client drives an address, write data, a chip enable and an active-low write strobe. All of these are sampled on the rising clock edge. Writes take effect at that edge. Read data is registered and comes out one cycle after the request. When the block is not being read, the read data output is forced to zero; it is never left floating. A write aimed at the read-only bank is dropped without notice.

Top module: `mixmem_top`

## Requirements
- R1: While `rstN` is low and after its release, `rdData` is 0 until the first read cycle completes.
- R2: A read (`ce`=1, `wrN`=1) with `addr[11:10]`=00 returns the constant word for the 12-bit address a, which is a[7:0] XOR 0xA5 XOR {a[9:8],a[9:8],a[9:8],a[9:8]}.
- R3: Bank codes 01, 10 and 11 in `addr[11:10]` are writable. A byte written at any address in them, including the first and last word of each bank, reads back unchanged.
- R4: A word is stored only at a rising edge with `ce`=1 and `wrN`=0. With `ce`=0 and `wrN`=0, or with `ce`=1 and `wrN`=1, the stored word does not change.
- R5: A write cycle with `addr[11:10]`=00 is ignored. A later read of that address still returns the R2 constant.
- R6: Read data for a request sampled at edge k appears on `rdData` just after edge k and holds until edge k+1. A write at edge k is visible to a read sampled at edge k+1.
- R7: A cycle with `ce`=0 makes `rdData` 0 after the following edge.
- R8: A write cycle (`ce`=1, `wrN`=0) makes `rdData` 0 after the following edge.
- R9: The bank is chosen only by `addr[11:10]`. The same `addr[9:0]` in different writable banks holds independent words.

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset of the read register |
| addr | input | 12 | Word address; bits 11:10 pick the bank |
| wrData | input | 8 | Byte to store on a write cycle |
| ce | input | 1 | Chip enable, active high |
| wrN | input | 1 | Write strobe, active low; high means read |
| rdData | output | 8 | Registered read data; 0 when not reading |

## Verification
A wrong bank decode shows up on the first read after a write. Either the written byte is missing, or it appears under another bank's address or in place of a read-only constant. That failure is visible exactly one cycle after the read request. A broken write gate changes a word that should have stayed the same, and this shows at the next read of that word. A broken output gate leaves stale data on `rdData` one cycle after a disable or write cycle, where zero is expected.

// File: rtl/mixmem_pkg.sv
package mixmem_pkg;
  parameter int ADDR_W = 12;
  parameter int DATA_W = 8;
  parameter int BANK_AW = 10;
  parameter int ROM_BANKS = 1;
  localparam int BANK_SEL_W = ADDR_W - BANK_AW;
  localparam int NUM_BANKS = 1 << BANK_SEL_W;
  localparam int BANK_WORDS = 1 << BANK_AW;

  typedef struct packed {
    logic [NUM_BANKS-1:0] bankHot;
    logic                 wrEn;
    logic                 rdEn;
  } memStrobes_t;

  function automatic logic [DATA_W-1:0] romValue(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ 8'hA5 ^ {a[9:8], a[9:8], a[9:8], a[9:8]};
  endfunction
endpackage

// File: rtl/mixmem_ctrl.sv
module mixmem_ctrl
  import mixmem_pkg::*;
(
  input  logic                  ce,
  input  logic                  wrN,
  input  logic [BANK_SEL_W-1:0] bankSel,
  output memStrobes_t           strb
);
  always_comb begin
    for (int i = 0; i < NUM_BANKS; i++) begin
      strb.bankHot[i] = ce && (bankSel == BANK_SEL_W'(i));
    end
    strb.wrEn = ce && !wrN && (int'(bankSel) >= ROM_BANKS);
    strb.rdEn = ce && wrN;
  end
endmodule

// File: rtl/mixmem_datapath.sv
module mixmem_datapath
  import mixmem_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  memStrobes_t        strb,
  input  logic [BANK_AW-1:0] index,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData
);
  logic [DATA_W-1:0] bankWord [NUM_BANKS];
  logic [DATA_W-1:0] selWord;

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      if (b < ROM_BANKS) begin : g_rom
        assign bankWord[b] = romValue(ADDR_W'(b * BANK_WORDS) | ADDR_W'(index));
      end else begin : g_ram
        logic [DATA_W-1:0] cells [BANK_WORDS];
        always_ff @(posedge clk) begin
          if (strb.wrEn && strb.bankHot[b]) cells[index] <= wrData;
        end
        assign bankWord[b] = cells[index];
      end
    end
  endgenerate

  always_comb begin
    selWord = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (strb.bankHot[i]) selWord = selWord | bankWord[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (strb.rdEn) rdData <= selWord;
    else rdData <= '0;
  end
endmodule

// File: rtl/mixmem_top.sv
module mixmem_top
  import mixmem_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ce,
  input  logic              wrN,
  output logic [DATA_W-1:0] rdData
);
  memStrobes_t strb;

  mixmem_ctrl u_ctrl (
    .ce(ce), .wrN(wrN), .bankSel(addr[ADDR_W-1:BANK_AW]), .strb(strb)
  );

  mixmem_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .index(addr[BANK_AW-1:0]),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/mixmem_chk.sv
module mixmem_chk
  import mixmem_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              ce,
  input logic              wrN,
  input logic [DATA_W-1:0] rdData
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) !rstN |=> rdData == '0);

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ce |=> rdData == '0);

  // R8
  write_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ce && !wrN) |=> rdData == '0);

  // R2
  rom_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ce && wrN && addr[ADDR_W-1:BANK_AW] == '0) |=> rdData == romValue($past(addr)));

  // R6
  wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ce && wrN && $past(ce && !wrN && addr[ADDR_W-1:BANK_AW] != '0)
     && addr == $past(addr)) |=> rdData == $past(wrData, 2));
endmodule

bind mixmem_top mixmem_chk u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
  .ce(ce), .wrN(wrN), .rdData(rdData)
);

// File: tb/mixmem_top_tb.sv
module mixmem_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic        ce = 1'b0;
  logic        wrN = 1'b1;
  logic [7:0]  rdData;
  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mixmem_top u_dut (.clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
                    .ce(ce), .wrN(wrN), .rdData(rdData));

  function automatic logic [7:0] romExp(input logic [11:0] a);
    return a[7:0] ^ 8'hA5 ^ {a[9:8], a[9:8], a[9:8], a[9:8]};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic w, input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    ce = c; wrN = w; addr = a; wrData = d;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    cyc(1'b1, 1'b0, a, d);
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] q);
    cyc(1'b1, 1'b1, a, 8'h00);
    q = rdData;
  endtask

  task automatic test_reset();
    @(negedge clk); check("R1 in reset", rdData, 8'h00);
    @(negedge clk); rstN = 1'b1;
    cyc(1'b0, 1'b1, 12'h000, 8'h00);
    check("R1 after release", rdData, 8'h00);
  endtask

  task automatic test_rom_read();
    logic [7:0] q;
    logic [11:0] list [4] = '{12'h000, 12'h3FF, 12'h155, 12'h2AA};
    foreach (list[i]) begin
      rd(list[i], q);
      check("R2 rom read", q, romExp(list[i]));
    end
  endtask

  task automatic test_ram_edges();
    logic [7:0] q;
    logic [11:0] list [6] = '{12'h400, 12'h7FF, 12'h800, 12'hBFF, 12'hC00, 12'hFFF};
    foreach (list[i]) wr(list[i], 8'h30 + 8'(i));
    foreach (list[i]) begin
      rd(list[i], q);
      check("R3 ram edge readback", q, 8'h30 + 8'(i));
    end
  endtask

  task automatic test_write_gate();
    logic [7:0] q;
    wr(12'h4AB, 8'h5C);
    cyc(1'b0, 1'b0, 12'h4AB, 8'hEE);
    rd(12'h4AB, q);
    check("R4 ce low write ignored", q, 8'h5C);
    cyc(1'b1, 1'b1, 12'h4AB, 8'h77);
    rd(12'h4AB, q);
    check("R4 read cycle stores nothing", q, 8'h5C);
  endtask

  task automatic test_rom_write();
    logic [7:0] q;
    wr(12'h010, 8'hFF);
    wr(12'h3FF, 8'h00);
    rd(12'h010, q);
    check("R5 rom write ignored low", q, romExp(12'h010));
    rd(12'h3FF, q);
    check("R5 rom write ignored top", q, romExp(12'h3FF));
  endtask

  task automatic test_latency();
    wr(12'h9A0, 8'hC3);
    cyc(1'b1, 1'b1, 12'h9A0, 8'h00);
    check("R6 write visible next read", rdData, 8'hC3);
    @(negedge clk);
    check("R6 data held to next edge", rdData, 8'hC3);
    ce = 1'b0;
    @(posedge clk); #1;
    check("R7 ce low clears output", rdData, 8'h00);
  endtask

  task automatic test_write_zero();
    logic [7:0] q;
    rd(12'h9A0, q);
    check("R6 read before write cycle", q, 8'hC3);
    wr(12'h9A1, 8'h11);
    check("R8 output zero in write cycle", rdData, 8'h00);
  endtask

  task automatic test_bank_indep();
    logic [7:0] q;
    wr(12'h405, 8'hA1);
    wr(12'h805, 8'hB2);
    wr(12'hC05, 8'hC4);
    rd(12'h405, q); check("R9 bank1 independent", q, 8'hA1);
    rd(12'h805, q); check("R9 bank2 independent", q, 8'hB2);
    rd(12'hC05, q); check("R9 bank3 independent", q, 8'hC4);
    rd(12'h005, q); check("R9 rom unaffected", q, romExp(12'h005));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_rom_read();
    test_ram_edges();
    test_write_gate();
    test_rom_write();
    test_latency();
    test_write_zero();
    test_bank_indep();
    cyc(1'b0, 1'b1, 12'h000, 8'h00);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule